// File: doc/BRIEF.md
# Serial Probe Signature Compressor

This block folds a serial stream of probe bits into a short signature using a four-stage linear-feedback shift register. Pulsing `start` clears the register and opens a capture window of a fixed number of clock edges. On each edge of that window the register moves one place toward its least significant end. The new top bit is formed from the two lowest bits and the probe bit.

When the last edge of the window has been taken, the register stops changing. Its value is copied to a held signature output and a completion flag goes high. A test harness drives a known stimulus into `probe` and compares `signature` against a golden value it keeps itself.

Top module: `sig_compressor`

## Requirements
- R1: Synchronous active-high `rst` sets `lfsr_q`, `signature` and `done` to zero and returns the block to idle.
- R2: When `start` is high at a rising edge, `lfsr_q` becomes 4'b0000 and `done` becomes 0. A capture window of WINDOW (default 10) edges begins on the following edge.
- R3: On each window edge the next value of bit 3 is bit 0 XOR bit 1 XOR `probe`. Bit 2 takes bit 3, bit 1 takes bit 2 and bit 0 takes bit 1. For example, from 0000 a probe of 1 gives 1000, and from 1000 a probe of 0 gives 0100.
- R4: `done` rises on exactly the WINDOW-th edge after the edge that sampled `start`. On that same edge `signature` takes the final register value.
- R5: While idle or done, `probe` is ignored and `lfsr_q` does not change.
- R6: `done` and `signature` hold until the next `start` or `rst`. A new `start` clears `done`, but `signature` keeps its previous value until the new window completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears the register and begins a capture window |
| probe | input | 1 | Serial probe bit that is compressed |
| lfsr_q | output | 4 | Live register contents (bit 3 top, bit 0 bottom) |
| signature | output | 4 | Signature held from the last completed window |
| done | output | 1 | High once a window has completed |

## Verification
The bench steps a reference model of the feedback law beside the design for several probe patterns, and compares the live register after every edge. A wrong tap or shift direction shows up as a mismatch within a few edges. It checks that `done` is low after nine window edges and high after ten, which catches an off-by-one counter. It also toggles `probe` while the block is idle and while it is done, and confirms that the register and signature stay put, so a design that keeps shifting after completion is exposed. A restart in the middle of a window checks that the register is cleared and the count starts again.

// File: rtl/sig_compressor_pkg.sv
package sig_compressor_pkg;
    localparam int SIG_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } cap_state_e;

    // One step of the compression law: top bit from the two lowest bits and probe.
    function automatic logic [SIG_W-1:0] lfsr_step(input logic [SIG_W-1:0] cur,
                                                  input logic           bit_in);
        return {cur[0] ^ cur[1] ^ bit_in, cur[SIG_W-1:1]};
    endfunction
endpackage

// File: rtl/sig_window_ctrl.sv
module sig_window_ctrl
    import sig_compressor_pkg::*;
#(
    parameter int WINDOW = 10,
    localparam int CW = $clog2(WINDOW + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       shift_en,
    output logic       finish,
    output cap_state_e state
);
    logic [CW-1:0] cnt_q;
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt_q <= '0;
        end else if (start) begin
            state <= ST_RUN;
            cnt_q <= '0;
        end else if (state == ST_RUN) begin
            if (cnt_q == LAST) state <= ST_DONE;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign shift_en = (state == ST_RUN) && !start;
    assign finish   = shift_en && (cnt_q == LAST);

    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (cnt_q <= LAST));
    a_r2_start_runs: assert property (@(posedge clk) disable iff (rst)
        start |=> (state == ST_RUN) && (cnt_q == '0));
endmodule

// File: rtl/sig_lfsr.sv
module sig_lfsr
    import sig_compressor_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [SIG_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clear) q <= '0;
        else if (shift_en) q <= lfsr_step(q, bit_in);
    end

    a_r3_shift_down: assert property (@(posedge clk) disable iff (rst || clear)
        shift_en |=> (q[SIG_W-2:0] == $past(q[SIG_W-1:1])));
    a_r3_feedback: assert property (@(posedge clk) disable iff (rst || clear)
        shift_en |=> (q[SIG_W-1] == ($past(q[0]) ^ $past(q[1]) ^ $past(bit_in))));
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !clear) |=> $stable(q));
endmodule

// File: rtl/sig_compressor.sv
module sig_compressor
    import sig_compressor_pkg::*;
#(
    parameter int WINDOW = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             probe,
    output logic [SIG_W-1:0] lfsr_q,
    output logic [SIG_W-1:0] signature,
    output logic             done
);
    logic       shift_en;
    logic       finish;
    cap_state_e state;

    sig_window_ctrl #(.WINDOW(WINDOW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .shift_en(shift_en), .finish(finish), .state(state)
    );

    sig_lfsr u_lfsr (
        .clk(clk), .rst(rst), .clear(start), .shift_en(shift_en),
        .bit_in(probe), .q(lfsr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            signature <= '0;
            done      <= 1'b0;
        end else if (start) begin
            done <= 1'b0;
        end else if (finish) begin
            signature <= lfsr_step(lfsr_q, probe);
            done      <= 1'b1;
        end
    end

    a_r4_sig_matches: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (signature == lfsr_q));
    a_r6_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done && $stable(signature));
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (lfsr_q == '0) && (signature == '0) && !done);
    a_r4_done_state: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == ST_DONE));
endmodule

// File: tb/sig_compressor_tb.sv
module sig_compressor_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       probe = 1'b0;
    logic [3:0] lfsr_q;
    logic [3:0] signature;
    logic       done;
    int         n_chk = 0;
    int         n_err = 0;
    logic [3:0] model;
    logic [3:0] last_sig;

    always #5 clk = ~clk;

    sig_compressor #(.WINDOW(10)) u_dut (
        .clk(clk), .rst(rst), .start(start), .probe(probe),
        .lfsr_q(lfsr_q), .signature(signature), .done(done)
    );

    function automatic logic [3:0] ref_step(input logic [3:0] s, input logic p);
        return {s[0] ^ s[1] ^ p, s[3], s[2], s[1]};
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Edge then settle: drives change only after the negative edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_start();
        start = 1'b1;
        tick();
        start = 1'b0;
        model = 4'b0000;
        check("R2", lfsr_q, 4'b0000);
        check("R2", {3'b0, done}, 4'd0);
    endtask

    task automatic run_window(input logic [9:0] pat);
        do_start();
        for (int i = 0; i < 10; i++) begin
            probe = pat[i];
            tick();
            model = ref_step(model, pat[i]);
            check("R3", lfsr_q, model);
            if (i == 8) check("R4", {3'b0, done}, 4'd0);
        end
        check("R4", {3'b0, done}, 4'd1);
        check("R4", signature, model);
        last_sig = model;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        check("R1", lfsr_q, 4'b0000);
        check("R1", signature, 4'b0000);
        check("R1", {3'b0, done}, 4'd0);
    endtask

    task automatic t_known_steps();
        do_start();
        probe = 1'b1;
        tick();
        check("R3", lfsr_q, 4'b1000);
        probe = 1'b0;
        tick();
        check("R3", lfsr_q, 4'b0100);
    endtask

    task automatic t_idle_ignore();
        logic [3:0] held;
        held = lfsr_q;
        for (int i = 0; i < 6; i++) begin
            probe = i[0];
            tick();
            check("R5", lfsr_q, held);
        end
    endtask

    task automatic t_done_hold();
        for (int i = 0; i < 5; i++) begin
            probe = ~probe;
            tick();
            check("R5", lfsr_q, last_sig);
            check("R6", signature, last_sig);
            check("R6", {3'b0, done}, 4'd1);
        end
    endtask

    task automatic t_restart();
        logic [3:0] prev;
        prev = signature;
        do_start();
        check("R6", signature, prev);
        for (int i = 0; i < 4; i++) begin
            probe = 1'b1;
            tick();
        end
        run_window(10'b10_1100_1011);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        model = '0;
        last_sig = '0;
        @(negedge clk);
        t_reset();
        t_idle_ignore();
        t_known_steps();
        rst = 1'b1; tick(); rst = 1'b0;
        run_window(10'b11_1111_1111);
        t_done_hold();
        run_window(10'b00_0000_0001);
        t_done_hold();
        run_window(10'b01_0101_0110);
        t_restart();
        t_done_hold();
        t_reset();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule